// File: doc/BRIEF.md
# Strobe-to-Clock Write Alignment Trainer

This block is a one-shot training sequencer used while a DDR memory interface is being brought up. Its job is to find the delay setting for the write strobe at which the strobe's rising edge arrives at the memory device together with the rising edge of the device clock. During training the strobe acts as a probe that the controller drives. The memory samples its own clock level on each strobe rising edge and returns that level on one data bit. The trainer steps a delay tap upward from zero and stops at the first tap where the returned level turns from low to high compared with the tap before it.

A start pulse begins a run. The block first requests that the memory enter its alignment mode and raises a termination request for the whole run. At every tap it waits for the external delay line to settle, then fires a fixed number of single-cycle strobe pulses. It collects one feedback sample per pulse and takes a majority vote, so one noisy sample cannot decide the result. When the search ends, either because the edge was found or because the highest tap was passed without an edge, the block requests that alignment mode be turned off. It raises done only after that request is acknowledged. The tap, done and error outputs then hold until the next start.

The delay line, the mode-register command path, the termination control and the memory device sit outside this block.

Top module: `wlt_trainer`

## Requirements
- R1: While reset is held and right after it, every request output, the strobe output, done and error are low and the tap output is 0.
- R2: A start pulse seen while the block is idle or done raises the enable request and the termination request in the next cycle and sets the tap to 0. The enable request stays high until its acknowledge is seen high.
- R3: After the tap is set, whether by the first setting after the enable acknowledge or by any later step, at least SETTLE_CYC cycles (default 8) pass before the next strobe pulse.
- R4: At each tap the block fires PULSES (default 4) strobe pulses, each high for exactly one cycle. After each pulse it waits for a cycle with feedback-valid high before firing the next. The tap's vote is 1 only when at least 3 of the 4 sampled feedback bits are 1, so a 2-to-2 split votes 0.
- R5: The tap rises by exactly one per step. The search stops at the first tap whose vote is 1 while the previous tap's vote was 0, and the tap output keeps that value. A vote of 1 at tap 0 never counts as an edge.
- R6: If tap 63 is voted without an edge being found, the error output goes high and the tap output returns to 0.
- R7: At the end of a search the disable request is raised and held until its acknowledge is seen high. Done rises in the cycle after that acknowledge, and at that point the termination request is low.
- R8: Done, error and tap hold their values until the next start. A start pulse that arrives while a run is in progress is ignored.
- R9: A start after done runs a complete new search from tap 0, and the error flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a training run |
| lvl_en_req_o | output | 1 | Request to put the memory into alignment mode |
| lvl_en_ack_i | input | 1 | Acknowledge for the enable request |
| lvl_dis_req_o | output | 1 | Request to take the memory out of alignment mode |
| lvl_dis_ack_i | input | 1 | Acknowledge for the disable request |
| term_req_o | output | 1 | Termination override request, high while a run is active |
| strobe_pulse_o | output | 1 | One-cycle command to fire a probe strobe |
| fb_valid_i | input | 1 | Feedback sample present this cycle |
| fb_bit_i | input | 1 | Clock level sampled by the memory on the strobe edge |
| tap_o | output | TAP_W (6) | Delay tap setting for the strobe |
| done_o | output | 1 | Run finished and alignment mode disabled |
| err_o | output | 1 | No low-to-high edge found across all taps |

## Verification
The assertions assume that each acknowledge is a level that follows its request and stays low while that request is low. They also assume that a feedback-valid cycle arrives only after a strobe pulse, with no new valid before the next pulse. The bench models the handshake partner as a one-cycle echo of each request. Its memory model returns exactly one valid sample two half-cycles after every strobe pulse, and the feedback level depends only on the current tap and the index of the pulse within that tap. Start is pulsed for one cycle, and the bench pulses it mid-run only in the test that checks it is ignored.

// File: rtl/wlt_pkg.sv
package wlt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN,
        ST_SETTLE,
        ST_PULSE,
        ST_WAIT,
        ST_DECIDE,
        ST_DIS,
        ST_DONE
    } wlt_state_e;

endpackage

// File: rtl/wlt_settle_timer.sv
module wlt_settle_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          run;
    } tmr_t;

    tmr_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = CW'(CYC - 1);
            r_d.run = 1'b1;
        end else if (r_q.run) begin
            if (r_q.cnt != '0) begin
                r_d.cnt = r_q.cnt - 1'b1;
            end else begin
                r_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired_o = r_q.run && (r_q.cnt == '0);

endmodule

// File: rtl/wlt_vote.sv
module wlt_vote #(
    parameter int PULSES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          smp_i,
    input  logic                          bit_i,
    output logic [$clog2(PULSES+1)-1:0]   cnt_o,
    output logic                          vote_o
);
    localparam int CW     = $clog2(PULSES + 1);
    localparam int THRESH = PULSES / 2 + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] ones;
    } vote_t;

    vote_t v_q, v_d;

    always_comb begin
        v_d = v_q;
        if (clr_i) begin
            v_d = '0;
        end else if (smp_i) begin
            v_d.cnt  = v_q.cnt + 1'b1;
            v_d.ones = v_q.ones + CW'(bit_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign cnt_o  = v_q.cnt;
    assign vote_o = (v_q.ones >= CW'(THRESH));

endmodule

// File: rtl/wlt_trainer.sv
module wlt_trainer #(
    parameter int TAP_W      = 6,
    parameter int PULSES     = 4,
    parameter int SETTLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             lvl_en_req_o,
    input  logic             lvl_en_ack_i,
    output logic             lvl_dis_req_o,
    input  logic             lvl_dis_ack_i,
    output logic             term_req_o,
    output logic             strobe_pulse_o,
    input  logic             fb_valid_i,
    input  logic             fb_bit_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             done_o,
    output logic             err_o
);
    import wlt_pkg::*;

    localparam int                CW      = $clog2(PULSES + 1);
    localparam logic [TAP_W-1:0]  TAP_MAX = {TAP_W{1'b1}};

    typedef struct packed {
        wlt_state_e       st;
        logic [TAP_W-1:0] tap;
        logic             prev;
        logic             err;
    } ctl_t;

    ctl_t c_q, c_d;

    logic          tmr_load;
    logic          tmr_exp;
    logic          v_clr;
    logic          v_smp;
    logic [CW-1:0] v_cnt;
    logic          v_vote;

    wlt_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_exp)
    );

    wlt_vote #(.PULSES(PULSES)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (v_clr),
        .smp_i  (v_smp),
        .bit_i  (fb_bit_i),
        .cnt_o  (v_cnt),
        .vote_o (v_vote)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        v_clr    = 1'b0;
        v_smp    = 1'b0;
        unique case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    c_d.st   = ST_EN;
                    c_d.tap  = '0;
                    c_d.prev = 1'b1;
                    c_d.err  = 1'b0;
                    v_clr    = 1'b1;
                end
            end
            ST_EN: begin
                if (lvl_en_ack_i) begin
                    c_d.st   = ST_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_exp) begin
                    c_d.st = ST_PULSE;
                end
            end
            ST_PULSE: begin
                c_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (fb_valid_i) begin
                    v_smp  = 1'b1;
                    c_d.st = (v_cnt == CW'(PULSES - 1)) ? ST_DECIDE : ST_PULSE;
                end
            end
            ST_DECIDE: begin
                v_clr = 1'b1;
                if (!c_q.prev && v_vote) begin
                    c_d.st = ST_DIS;
                end else if (c_q.tap == TAP_MAX) begin
                    c_d.st  = ST_DIS;
                    c_d.err = 1'b1;
                    c_d.tap = '0;
                end else begin
                    c_d.st   = ST_SETTLE;
                    c_d.tap  = c_q.tap + 1'b1;
                    c_d.prev = v_vote;
                    tmr_load = 1'b1;
                end
            end
            ST_DIS: begin
                if (lvl_dis_ack_i) begin
                    c_d.st = ST_DONE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.tap  <= '0;
            c_q.prev <= 1'b1;
            c_q.err  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign lvl_en_req_o   = (c_q.st == ST_EN);
    assign lvl_dis_req_o  = (c_q.st == ST_DIS);
    assign strobe_pulse_o = (c_q.st == ST_PULSE);
    assign done_o         = (c_q.st == ST_DONE);
    assign term_req_o     = (c_q.st != ST_IDLE) && (c_q.st != ST_DONE);
    assign tap_o          = c_q.tap;
    assign err_o          = c_q.err;

endmodule

// File: rtl/wlt_trainer_chk.sv
module wlt_trainer_chk #(
    parameter int TAP_W      = 6,
    parameter int SETTLE_CYC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             lvl_en_req_o,
    input logic             lvl_en_ack_i,
    input logic             lvl_dis_req_o,
    input logic             lvl_dis_ack_i,
    input logic             term_req_o,
    input logic             strobe_pulse_o,
    input logic [TAP_W-1:0] tap_o,
    input logic             done_o,
    input logic             err_o
);
    localparam int AW = $clog2(SETTLE_CYC + 2);

    logic [TAP_W-1:0] prev_tap_q;
    logic             prev_en_q;
    logic [AW-1:0]    age_q;
    logic             restart;
    logic [AW-1:0]    age;

    assign restart = (tap_o != prev_tap_q) || (prev_en_q && !lvl_en_req_o);
    assign age     = restart ? '0 : age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tap_q <= '0;
            prev_en_q  <= 1'b0;
            age_q      <= '0;
        end else begin
            prev_tap_q <= tap_o;
            prev_en_q  <= lvl_en_req_o;
            if (restart) begin
                age_q <= AW'(1);
            end else if (age_q < AW'(SETTLE_CYC)) begin
                age_q <= age_q + 1'b1;
            end
        end
    end

    p_start_tap0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_en_req_o) |-> $past(start_i) && (tap_o == '0) && term_req_o);

    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_en_req_o && !lvl_en_ack_i) |=> lvl_en_req_o);

    p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_pulse_o |-> (age >= AW'(SETTLE_CYC)));

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_pulse_o |=> !strobe_pulse_o);

    p_tap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req_o && !$stable(tap_o)) |-> ((tap_o == TAP_W'($past(tap_o) + 1'b1)) || (tap_o == '0)));

    p_err_tap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (tap_o == '0));

    p_dis_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_dis_req_o && !lvl_dis_ack_i) |=> lvl_dis_req_o);

    p_done_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(lvl_dis_ack_i) && $past(lvl_dis_req_o));

    p_req_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(lvl_en_req_o && lvl_dis_req_o));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(tap_o) && $stable(err_o));

    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req_o && !lvl_en_req_o && start_i) |=> !lvl_en_req_o);

endmodule

bind wlt_trainer wlt_trainer_chk #(.TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .lvl_en_req_o   (lvl_en_req_o),
    .lvl_en_ack_i   (lvl_en_ack_i),
    .lvl_dis_req_o  (lvl_dis_req_o),
    .lvl_dis_ack_i  (lvl_dis_ack_i),
    .term_req_o     (term_req_o),
    .strobe_pulse_o (strobe_pulse_o),
    .tap_o          (tap_o),
    .done_o         (done_o),
    .err_o          (err_o)
);

// File: tb/sim_wlt_trainer.sv
`timescale 1ns/1ps
module sim_wlt_trainer;
    localparam int SETTLE = 8;
    localparam int NVEC   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       en_ack = 1'b0;
    logic       dis_ack = 1'b0;
    logic       fb_valid = 1'b0;
    logic       fb_bit = 1'b0;
    logic       en_req, dis_req, term_req, strobe, done, err;
    logic [5:0] tap;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    int  m_edge = 64;
    int  m_low  = 0;
    int  m_noise = 0;
    int  pulses = 0;
    int  settle_bad = 0;
    int  last_set = 0;
    int  pidx = 0;
    int  last_tap = 0;
    bit  fb_pend = 0;
    bit  prev_en = 0;
    bit  saw_dis_ack = 0;

    // {edge[7], low[6], noise[2], exp_tap[6], exp_err[1]}
    localparam logic [21:0] VEC [NVEC] = '{
        {7'd5,  6'd0, 2'd0, 6'd5,  1'b0},
        {7'd1,  6'd0, 2'd0, 6'd1,  1'b0},
        {7'd63, 6'd0, 2'd0, 6'd63, 1'b0},
        {7'd64, 6'd0, 2'd0, 6'd0,  1'b1},
        {7'd0,  6'd0, 2'd0, 6'd0,  1'b1},
        {7'd10, 6'd3, 2'd0, 6'd10, 1'b0},
        {7'd7,  6'd0, 2'd1, 6'd7,  1'b0},
        {7'd12, 6'd0, 2'd2, 6'd12, 1'b0}
    };

    always #2 clk = ~clk;

    wlt_trainer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .lvl_en_req_o(en_req), .lvl_en_ack_i(en_ack),
        .lvl_dis_req_o(dis_req), .lvl_dis_ack_i(dis_ack),
        .term_req_o(term_req), .strobe_pulse_o(strobe),
        .fb_valid_i(fb_valid), .fb_bit_i(fb_bit),
        .tap_o(tap), .done_o(done), .err_o(err)
    );

    function automatic bit level_at(int t, int idx);
        bit lv;
        lv = (t >= m_edge) ? 1'b1 : ((t >= m_low) ? 1'b0 : 1'b1);
        if (m_noise == 1 && idx == 0) lv = ~lv;
        if (m_noise == 2 && t < m_edge && idx < 2) lv = 1'b1;
        return lv;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // handshake partner, memory feedback model and cycle monitor
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            en_ack  = en_req;
            dis_ack = dis_req;
            if (dis_req && dis_ack) saw_dis_ack = 1;
            if (int'(tap) != last_tap) begin
                last_tap = int'(tap);
                last_set = cyc;
                pidx = 0;
            end
            if (prev_en && !en_req) begin
                last_set = cyc;
                pidx = 0;
            end
            prev_en = en_req;
            if (fb_pend) begin
                fb_valid = 1'b1;
                fb_bit   = level_at(int'(tap), pidx);
                pidx++;
                fb_pend  = 0;
            end else begin
                fb_valid = 1'b0;
            end
            if (strobe) begin
                pulses++;
                if (cyc - last_set < SETTLE) settle_bad++;
                fb_pend = 1;
            end
        end
    end

    task automatic kick();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done) begin
                ok = 1;
                break;
            end
        end
    endtask

    task automatic run_one(input int edge_t, input int low, input int noise,
                           input int exp_tap, input bit exp_err, input bit busy_kick);
        bit ok;
        int exp_p;
        m_edge = edge_t; m_low = low; m_noise = noise;
        pulses = 0; settle_bad = 0; saw_dis_ack = 0;
        kick();
        chk(en_req === 1'b1 && term_req === 1'b1, "R2 enable+term request after start", {en_req, term_req}, 3);
        chk(tap === 6'd0, "R9 restart at tap 0", int'(tap), 0);
        if (busy_kick) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk(ok, "R7 done reached (watchdog)", ok, 1);
        if (!ok) return;
        chk(int'(tap) == exp_tap, "R5/R6 final tap", int'(tap), exp_tap);
        chk(err === exp_err, "R6/R9 error flag", err, exp_err);
        exp_p = exp_err ? 256 : (exp_tap + 1) * 4;
        chk(pulses == exp_p, "R4/R8 strobe pulse count", pulses, exp_p);
        chk(settle_bad == 0, "R3 settle gap before strobe", settle_bad, 0);
        chk(saw_dis_ack && term_req === 1'b0, "R7 disable acked and term low at done", {saw_dis_ack, term_req}, 2);
        repeat (5) @(negedge clk);
        chk(done === 1'b1 && int'(tap) == exp_tap && err === exp_err, "R8 outputs hold after done",
            int'(tap), exp_tap);
    endtask

    initial begin
        int wd_fail;
        wd_fail = 0;
        fork
            begin
                repeat (150000) @(posedge clk);
                wd_fail = 1;
            end
            begin
                repeat (3) @(negedge clk);
                chk(en_req === 0 && dis_req === 0 && term_req === 0 && strobe === 0 &&
                    done === 0 && err === 0 && tap === 6'd0, "R1 outputs during reset", int'(tap), 0);
                rst_n = 1'b1;
                repeat (3) @(negedge clk);
                chk(en_req === 0 && term_req === 0 && done === 0 && tap === 6'd0, "R1 idle after reset",
                    {en_req, term_req, done}, 0);

                for (int v = 0; v < NVEC; v++) begin
                    run_one(int'(VEC[v][21:15]), int'(VEC[v][14:9]), int'(VEC[v][8:7]),
                            int'(VEC[v][6:1]), VEC[v][0], 1'b0);
                end

                // R8: start pulsed mid-run is ignored
                run_one(20, 0, 0, 20, 1'b0, 1'b1);
                // R9: error then clean restart
                run_one(64, 0, 0, 0, 1'b1, 1'b0);
                run_one(3, 0, 0, 3, 1'b0, 1'b0);
            end
        join_any
        disable fork;
        if (wd_fail) chk(0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule